// File: doc/BRIEF.md
# Deferred-Fault Register File with Poison Tracking

This block is a small general register file in which every entry carries one extra poison bit. The bit records that the value in the entry stands for a fault that was deferred. A load issued ahead of a branch it used to follow may hit a fault the program can see, such as a misaligned address. Such a load does not trap. It writes an exception descriptor into its destination and marks that entry poisoned. A fault the program cannot see, such as a page miss, is still reported at once on the trap output, and the entry keeps its old contents. Ordinary loads that fault always trap and write nothing.

An ALU result inherits poison from any poisoned source, together with that source's descriptor. A chain of dependent work therefore carries the deferred fault forward. A check operation placed where the load originally sat names a register and a repair address. A clean register lets execution continue. A poisoned register raises a redirect to the repair address in the same cycle. The store request port only qualifies requests: it refuses any store flagged as speculative.

Top module: `poison_rf`

## Requirements
- R1: While rst_n is low, and after it is released, every register reads as zero with its poison bit clear.
- R2: With wr_en high, a write takes effect at the next rising clock edge, stores wr_data and clears the poison bit. This applies to an ALU write (wr_kind 2'b00) with clean sources, a normal load (2'b01) without a fault, and a speculative load (2'b10) without a fault. Kind 2'b11 writes nothing, and registers not addressed are unchanged.
- R3: A speculative load (2'b10) with ld_fault and ld_fault_vis high writes ld_fault_code, zero-extended to XLEN, into the destination and sets its poison bit. It keeps trap_valid low.
- R4: A speculative load with ld_fault high and ld_fault_vis low raises trap_valid with trap_code equal to ld_fault_code in the same cycle and leaves the destination unchanged. trap_code is zero whenever trap_valid is low.
- R5: A normal load (2'b01) with ld_fault high raises trap_valid with the fault code, whatever ld_fault_vis is, and leaves the destination unchanged.
- R6: An ALU write with a poisoned source ignores wr_data. It writes the poisoned source's stored value and sets the destination's poison bit. When both sources are poisoned, the source named by wr_src_a is used.
- R7: A check (chk_en high) of a clean register leaves redir_valid low.
- R8: A check of a poisoned register drives redir_valid high and redir_tgt equal to chk_tgt in that same cycle. With chk_en low, or with no redirect, redir_valid is low and redir_tgt is zero.
- R9: Read ports and the check see a write aimed at the same register in the same cycle, with that write's resolved data and poison.
- R10: A store request (st_valid high) with st_spec high gives st_error high and st_accept low. Without st_spec it gives st_accept high and st_error low. With st_valid low both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | NRD x AW | Register index for each read port |
| rd_data | output | NRD x XLEN | Read data, including same-cycle writes |
| rd_psn | output | NRD | Poison bit for each read port |
| wr_en | input | 1 | Write operation valid |
| wr_kind | input | 2 | 00 ALU, 01 load, 10 speculative load, 11 no write |
| wr_addr | input | AW | Destination register |
| wr_data | input | XLEN | Result or load data |
| wr_src_a | input | AW | First ALU source register, used for poison inheritance |
| wr_src_b | input | AW | Second ALU source register |
| ld_fault | input | 1 | The load hit a fault |
| ld_fault_vis | input | 1 | The fault is visible to the program |
| ld_fault_code | input | CODEW | Fault code |
| trap_valid | output | 1 | Fault reported immediately |
| trap_code | output | CODEW | Code of the reported fault |
| chk_en | input | 1 | Check operation valid |
| chk_addr | input | AW | Register to check |
| chk_tgt | input | TGTW | Repair address |
| redir_valid | output | 1 | Redirect to the repair address |
| redir_tgt | output | TGTW | Redirect address |
| st_valid | input | 1 | Store request valid |
| st_spec | input | 1 | Store request is marked speculative |
| st_accept | output | 1 | Store request accepted |
| st_error | output | 1 | Speculative store refused |

## Verification
A lost or stuck poison bit shows up at the first check of that register as a missing or spurious redirect. It shows up on the next read of the register as a wrong rd_psn, one edge after the write that should have set or cleared it. A wrong descriptor or a wrong source choice in poison inheritance appears as wrong rd_data on that same next read. A broken write bypass shows only in the cycle of the write itself, so the bench checks a read and a check together with a write to the same register.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;

  typedef enum logic [1:0] {
    WK_ALU  = 2'b00,
    WK_LOAD = 2'b01,
    WK_SPEC = 2'b10,
    WK_NONE = 2'b11
  } wkind_e;

endpackage

// File: rtl/poison_rf_resolve.sv
module poison_rf_resolve
  import poison_rf_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CODEW = 8,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [AW-1:0]    wr_addr,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             ld_fault,
  input  logic             ld_fault_vis,
  input  logic [CODEW-1:0] ld_fault_code,
  input  logic [XLEN-1:0]  src_a_data,
  input  logic             src_a_psn,
  input  logic [XLEN-1:0]  src_b_data,
  input  logic             src_b_psn,
  output logic             res_we,
  output logic [AW-1:0]    res_wa,
  output logic [XLEN-1:0]  res_wd,
  output logic             res_wp,
  output logic             trap_valid,
  output logic [CODEW-1:0] trap_code
);

  localparam int PADW = XLEN - CODEW;

  wkind_e kind;
  logic [XLEN-1:0] descr;

  assign kind   = wkind_e'(wr_kind);
  assign descr  = {{PADW{1'b0}}, ld_fault_code};
  assign res_wa = wr_addr;

  always_comb begin
    res_we     = 1'b0;
    res_wd     = wr_data;
    res_wp     = 1'b0;
    trap_valid = 1'b0;
    trap_code  = '0;
    if (wr_en) begin
      case (kind)
        WK_ALU: begin
          res_we = 1'b1;
          if (src_a_psn) begin
            res_wd = src_a_data;
            res_wp = 1'b1;
          end else if (src_b_psn) begin
            res_wd = src_b_data;
            res_wp = 1'b1;
          end
        end
        WK_LOAD: begin
          if (ld_fault) begin
            trap_valid = 1'b1;
            trap_code  = ld_fault_code;
          end else begin
            res_we = 1'b1;
          end
        end
        WK_SPEC: begin
          if (ld_fault && ld_fault_vis) begin
            res_we = 1'b1;
            res_wd = descr;
            res_wp = 1'b1;
          end else if (ld_fault) begin
            trap_valid = 1'b1;
            trap_code  = ld_fault_code;
          end else begin
            res_we = 1'b1;
          end
        end
        default: begin
          res_we = 1'b0;
        end
      endcase
    end
  end

  // A reported fault never also writes the register file
  assert_fault_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !res_we);

  // A visible speculative fault is deferred, never reported
  assert_visible_deferred_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'b10 && ld_fault && ld_fault_vis) |-> (!trap_valid && res_wp));

  // A poisoned ALU source always yields a poisoned result
  assert_alu_inherit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind == 2'b00 && (src_a_psn || src_b_psn)) |-> (res_we && res_wp));

endmodule

// File: rtl/poison_rf_store.sv
module poison_rf_store #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int AW   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              wa,
  input  logic [XLEN-1:0]            wd,
  input  logic                       wp,
  output logic [NREG-1:0][XLEN-1:0]  data_q,
  output logic [NREG-1:0]            psn_q
);

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic            en;
    logic [XLEN-1:0] data_d;
    logic            psn_d;

    always_comb begin
      en     = we && (wa == AW'(gi));
      data_d = wd;
      psn_d  = wp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[gi] <= '0;
        psn_q[gi]  <= 1'b0;
      end else if (en) begin
        data_q[gi] <= data_d;
        psn_q[gi]  <= psn_d;
      end
    end

    // Entries not addressed by a write keep value and poison
    assert_untouched_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && wa == AW'(gi)) |=> ($stable(data_q[gi]) && $stable(psn_q[gi])));
  end

  // A clean write lands with its data and clears poison
  assert_clean_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wp) |=> (data_q[$past(wa)] == $past(wd) && !psn_q[$past(wa)]));

  // A poisoned write leaves the entry marked
  assert_poison_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wp) |=> psn_q[$past(wa)]);

endmodule

// File: rtl/poison_rf_lookup.sv
module poison_rf_lookup #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int AW   = 4
) (
  input  logic [NREG-1:0][XLEN-1:0] data_q,
  input  logic [NREG-1:0]           psn_q,
  input  logic [AW-1:0]             addr,
  input  logic                      fwd_we,
  input  logic [AW-1:0]             fwd_wa,
  input  logic [XLEN-1:0]           fwd_wd,
  input  logic                      fwd_wp,
  output logic [XLEN-1:0]           q_data,
  output logic                      q_psn
);

  always_comb begin
    if (fwd_we && fwd_wa == addr) begin
      q_data = fwd_wd;
      q_psn  = fwd_wp;
    end else begin
      q_data = data_q[addr];
      q_psn  = psn_q[addr];
    end
  end

endmodule

// File: rtl/poison_rf_check.sv
module poison_rf_check #(
  parameter int TGTW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_en,
  input  logic            chk_psn,
  input  logic [TGTW-1:0] chk_tgt,
  input  logic            st_valid,
  input  logic            st_spec,
  output logic            redir_valid,
  output logic [TGTW-1:0] redir_tgt,
  output logic            st_accept,
  output logic            st_error
);

  always_comb begin
    redir_valid = chk_en && chk_psn;
    redir_tgt   = redir_valid ? chk_tgt : '0;
    st_accept   = st_valid && !st_spec;
    st_error    = st_valid && st_spec;
  end

  // Redirect only for an enabled check of a poisoned entry, to the given target
  assert_redir_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (chk_en && chk_psn && redir_tgt == chk_tgt));

  // Clean check never redirects
  assert_clean_noredir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !chk_psn) |-> !redir_valid);

  // Speculative store is never accepted
  assert_spec_store_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_spec) |-> (st_error && !st_accept));

endmodule

// File: rtl/poison_rf.sv
module poison_rf
  import poison_rf_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int XLEN  = 32,
  parameter int CODEW = 8,
  parameter int TGTW  = 32,
  parameter int NRD   = 2,
  parameter int AW    = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][XLEN-1:0]  rd_data,
  output logic [NRD-1:0]            rd_psn,
  input  logic                      wr_en,
  input  logic [1:0]                wr_kind,
  input  logic [AW-1:0]             wr_addr,
  input  logic [XLEN-1:0]           wr_data,
  input  logic [AW-1:0]             wr_src_a,
  input  logic [AW-1:0]             wr_src_b,
  input  logic                      ld_fault,
  input  logic                      ld_fault_vis,
  input  logic [CODEW-1:0]          ld_fault_code,
  output logic                      trap_valid,
  output logic [CODEW-1:0]          trap_code,
  input  logic                      chk_en,
  input  logic [AW-1:0]             chk_addr,
  input  logic [TGTW-1:0]           chk_tgt,
  output logic                      redir_valid,
  output logic [TGTW-1:0]           redir_tgt,
  input  logic                      st_valid,
  input  logic                      st_spec,
  output logic                      st_accept,
  output logic                      st_error
);

  logic [NREG-1:0][XLEN-1:0] data_q;
  logic [NREG-1:0]           psn_q;
  logic                      res_we;
  logic [AW-1:0]             res_wa;
  logic [XLEN-1:0]           res_wd;
  logic                      res_wp;
  logic [XLEN-1:0]           chk_data;
  logic                      chk_psn;

  poison_rf_resolve #(.XLEN(XLEN), .CODEW(CODEW), .AW(AW)) u_resolve (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_kind       (wr_kind),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .ld_fault      (ld_fault),
    .ld_fault_vis  (ld_fault_vis),
    .ld_fault_code (ld_fault_code),
    .src_a_data    (data_q[wr_src_a]),
    .src_a_psn     (psn_q[wr_src_a]),
    .src_b_data    (data_q[wr_src_b]),
    .src_b_psn     (psn_q[wr_src_b]),
    .res_we        (res_we),
    .res_wa        (res_wa),
    .res_wd        (res_wd),
    .res_wp        (res_wp),
    .trap_valid    (trap_valid),
    .trap_code     (trap_code)
  );

  poison_rf_store #(.NREG(NREG), .XLEN(XLEN), .AW(AW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (res_we),
    .wa     (res_wa),
    .wd     (res_wd),
    .wp     (res_wp),
    .data_q (data_q),
    .psn_q  (psn_q)
  );

  for (genvar gp = 0; gp < NRD; gp++) begin : g_rd
    poison_rf_lookup #(.NREG(NREG), .XLEN(XLEN), .AW(AW)) u_rd (
      .data_q (data_q),
      .psn_q  (psn_q),
      .addr   (rd_addr[gp]),
      .fwd_we (res_we),
      .fwd_wa (res_wa),
      .fwd_wd (res_wd),
      .fwd_wp (res_wp),
      .q_data (rd_data[gp]),
      .q_psn  (rd_psn[gp])
    );
  end

  poison_rf_lookup #(.NREG(NREG), .XLEN(XLEN), .AW(AW)) u_chk_rd (
    .data_q (data_q),
    .psn_q  (psn_q),
    .addr   (chk_addr),
    .fwd_we (res_we),
    .fwd_wa (res_wa),
    .fwd_wd (res_wd),
    .fwd_wp (res_wp),
    .q_data (chk_data),
    .q_psn  (chk_psn)
  );

  poison_rf_check #(.TGTW(TGTW)) u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_en      (chk_en),
    .chk_psn     (chk_psn),
    .chk_tgt     (chk_tgt),
    .st_valid    (st_valid),
    .st_spec     (st_spec),
    .redir_valid (redir_valid),
    .redir_tgt   (redir_tgt),
    .st_accept   (st_accept),
    .st_error    (st_error)
  );

  // A poisoned entry always carries a descriptor that fits the fault code width
  assert_descr_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_psn && !(res_we && res_wa == chk_addr)) |-> (chk_data[XLEN-1:CODEW] == '0));

endmodule

// File: tb/poison_rf_tb.sv
`timescale 1ns/1ps
module poison_rf_tb_top;

  localparam int NREG = 16;
  localparam int XLEN = 32;
  localparam int CODEW = 8;
  localparam int TGTW = 32;
  localparam int NRD = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NRD-1:0][AW-1:0]   rd_addr;
  logic [NRD-1:0][XLEN-1:0] rd_data;
  logic [NRD-1:0]           rd_psn;
  logic wr_en;
  logic [1:0] wr_kind;
  logic [AW-1:0] wr_addr, wr_src_a, wr_src_b, chk_addr;
  logic [XLEN-1:0] wr_data;
  logic ld_fault, ld_fault_vis;
  logic [CODEW-1:0] ld_fault_code, trap_code;
  logic trap_valid, chk_en, redir_valid, st_valid, st_spec, st_accept, st_error;
  logic [TGTW-1:0] chk_tgt, redir_tgt;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  poison_rf dut_i (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data), .rd_psn(rd_psn),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_src_a(wr_src_a), .wr_src_b(wr_src_b), .ld_fault(ld_fault),
    .ld_fault_vis(ld_fault_vis), .ld_fault_code(ld_fault_code),
    .trap_valid(trap_valid), .trap_code(trap_code), .chk_en(chk_en),
    .chk_addr(chk_addr), .chk_tgt(chk_tgt), .redir_valid(redir_valid),
    .redir_tgt(redir_tgt), .st_valid(st_valid), .st_spec(st_spec),
    .st_accept(st_accept), .st_error(st_error)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_kind = 2'b11; wr_addr = 0; wr_data = 0; wr_src_a = 0; wr_src_b = 0;
    ld_fault = 0; ld_fault_vis = 0; ld_fault_code = 0;
    chk_en = 0; chk_addr = 0; chk_tgt = 0; st_valid = 0; st_spec = 0;
    rd_addr[0] = 0; rd_addr[1] = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [1:0] k, input logic [AW-1:0] a, input logic [31:0] d,
                    input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                    input logic f, input logic v, input logic [7:0] c);
    wr_en = 1; wr_kind = k; wr_addr = a; wr_data = d; wr_src_a = sa; wr_src_b = sb;
    ld_fault = f; ld_fault_vis = v; ld_fault_code = c;
  endtask

  task automatic expect_reg(input string req, input logic [AW-1:0] a,
                            input logic [31:0] d, input logic p);
    rd_addr[1] = a;
    #1;
    check(req, rd_data[1], d);
    check(req, {31'b0, rd_psn[1]}, {31'b0, p});
  endtask

  task automatic t_reset();
    rst_n = 0; idle();
    #1;
    rd_addr[0] = 4'd7;
    #1;
    check("R1 in reset", rd_data[0], 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NREG; i++) expect_reg("R1", AW'(i), 0, 0);
  endtask

  task automatic t_clean();
    wr(2'b00, 4'd1, 32'h1234, 4'd0, 4'd0, 0, 0, 0); step();
    wr(2'b01, 4'd2, 32'hABCD, 4'd0, 4'd0, 0, 0, 0); step();
    wr(2'b10, 4'd3, 32'h55, 4'd0, 4'd0, 0, 0, 0); step();
    wr(2'b11, 4'd1, 32'h99, 4'd0, 4'd0, 0, 0, 0); step();
    expect_reg("R2 alu", 4'd1, 32'h1234, 0);
    expect_reg("R2 load", 4'd2, 32'hABCD, 0);
    expect_reg("R2 spec", 4'd3, 32'h55, 0);
    expect_reg("R2 untouched", 4'd4, 0, 0);
  endtask

  task automatic t_spec_visible();
    wr(2'b10, 4'd5, 32'hDEAD, 4'd0, 4'd0, 1, 1, 8'hA7);
    #1;
    check("R3 no trap", {31'b0, trap_valid}, 0);
    check("R4 trap_code zero", {24'b0, trap_code}, 0);
    step();
    expect_reg("R3 descriptor", 4'd5, 32'hA7, 1);
  endtask

  task automatic t_spec_invisible();
    wr(2'b10, 4'd3, 32'h77, 4'd0, 4'd0, 1, 0, 8'h0E);
    #1;
    check("R4 trap", {31'b0, trap_valid}, 1);
    check("R4 code", {24'b0, trap_code}, 32'h0E);
    step();
    expect_reg("R4 dest kept", 4'd3, 32'h55, 0);
  endtask

  task automatic t_load_fault();
    wr(2'b01, 4'd2, 32'h66, 4'd0, 4'd0, 1, 1, 8'h11);
    #1;
    check("R5 trap", {31'b0, trap_valid}, 1);
    check("R5 code", {24'b0, trap_code}, 32'h11);
    step();
    expect_reg("R5 dest kept", 4'd2, 32'hABCD, 0);
  endtask

  task automatic t_alu_prop();
    wr(2'b00, 4'd6, 32'h777, 4'd1, 4'd5, 0, 0, 0); step();
    expect_reg("R6 from b", 4'd6, 32'hA7, 1);
    wr(2'b10, 4'd7, 32'h0, 4'd0, 4'd0, 1, 1, 8'h3C); step();
    wr(2'b00, 4'd8, 32'h888, 4'd7, 4'd5, 0, 0, 0); step();
    expect_reg("R6 a wins", 4'd8, 32'h3C, 1);
    wr(2'b00, 4'd6, 32'h4242, 4'd1, 4'd2, 0, 0, 0); step();
    expect_reg("R2 clears poison", 4'd6, 32'h4242, 0);
  endtask

  task automatic t_check();
    chk_en = 1; chk_addr = 4'd1; chk_tgt = 32'h1000;
    #1;
    check("R7 clean", {31'b0, redir_valid}, 0);
    check("R8 tgt zero", redir_tgt, 0);
    chk_addr = 4'd5; chk_tgt = 32'h2040;
    #1;
    check("R8 redirect", {31'b0, redir_valid}, 1);
    check("R8 target", redir_tgt, 32'h2040);
    chk_en = 0;
    #1;
    check("R8 disabled", {31'b0, redir_valid}, 0);
    step();
  endtask

  task automatic t_forward();
    wr(2'b10, 4'd9, 32'h0, 4'd0, 4'd0, 1, 1, 8'h42);
    chk_en = 1; chk_addr = 4'd9; chk_tgt = 32'h3000; rd_addr[0] = 4'd9;
    #1;
    check("R9 chk sees poison", {31'b0, redir_valid}, 1);
    check("R9 read data", rd_data[0], 32'h42);
    check("R9 read psn", {31'b0, rd_psn[0]}, 1);
    step();
    wr(2'b01, 4'd5, 32'hBEEF, 4'd0, 4'd0, 0, 0, 0);
    chk_en = 1; chk_addr = 4'd5; chk_tgt = 32'h3100; rd_addr[0] = 4'd5;
    #1;
    check("R9 chk sees clean", {31'b0, redir_valid}, 0);
    check("R9 read new", rd_data[0], 32'hBEEF);
    step();
    expect_reg("R9 stored", 4'd5, 32'hBEEF, 0);
  endtask

  task automatic t_store();
    st_valid = 1; st_spec = 1;
    #1;
    check("R10 spec err", {30'b0, st_error, st_accept}, 32'h2);
    st_spec = 0;
    #1;
    check("R10 accept", {30'b0, st_error, st_accept}, 32'h1);
    st_valid = 0; st_spec = 1;
    #1;
    check("R10 idle", {30'b0, st_error, st_accept}, 0);
    step();
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 0;
    #1;
    rd_addr[0] = 4'd9;
    #1;
    check("R1 rerun data", rd_data[0], 0);
    check("R1 rerun psn", {31'b0, rd_psn[0]}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_en = 1; chk_addr = 4'd8; chk_tgt = 32'h5;
    #1;
    check("R1 no redirect", {31'b0, redir_valid}, 0);
    step();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_clean();
    t_spec_visible();
    t_spec_invisible();
    t_load_fault();
    t_alu_prop();
    t_check();
    t_forward();
    t_store();
    t_reset_again();
    finish_run();
  end

endmodule